// File: doc/BRIEF.md
# One-Time-Programmable Array Read Controller

This block sits on a simple register bus and reads words out of a one-time-programmable (OTP) array on software's behalf. Software first writes a word address into the address register, then writes a command word. If that word is the read command, the controller checks which region the address falls in. It then fetches one or two 32-bit words through a synchronous array read port with single-cycle latency. It places the result in two capture registers and reports completion or failure in a status register.

The array holds 4096 words. Words below 2048 form the data region, where each entry spans two consecutive words. The remaining words hold single-word configuration and strap entries. A data-region read fills both capture registers. A single-word read fills the first capture register and zeroes the second. An address past the end of the array is refused without touching the array. The program command is only recognised and flagged. Any other command value raises the error bit.

Top module: `otpReadCtrl`

## Requirements
- R1: After reset the status word, both capture registers, the region word and the address register read zero, and the array read enable is low.
- R2: A read command (0x23B1E361 written to byte offset 0x000) with an address register value (offset 0x010) below 2048 loads the word at that address into capture register 0 (offset 0x020) and the word at address+1 into capture register 1 (offset 0x024).
- R3: A read command with an address from 2048 to 4095 fetches exactly one word into capture register 0 and sets capture register 1 to zero.
- R4: A read command with an address of 4096 or more makes no array access, leaves both capture registers unchanged, clears done and sets the error bit.
- R5: Each array access presents the byte offset word-address × 4 on the array address port, and a two-word read accesses address and then address+1 in consecutive cycles.
- R6: If the array reports an error on either fetch of a read, the error bit is set, done stays clear, no further fetch is issued and both capture registers keep their previous values.
- R7: The program command 0x23B1E364 makes no array access, leaves the capture registers unchanged, sets the program flag and clears done and error.
- R8: Any other command value makes no array access and leaves the capture registers, busy and done unchanged, but sets the error bit.
- R9: The status word at offset 0x014 has busy in bit 0, done in bit 1, error in bit 2 and program flag in bit 3. Busy is high exactly while fetches are in progress, array reads happen only while busy, and done, error and program flag are cleared when a read or program command is accepted.
- R10: A command written while busy is dropped and has no effect on status or capture registers.
- R11: With the command write taken at clock edge E0, busy is seen from E0. A single-word read shows done after edge E0+2, and a two-word read shows done after edge E0+3.
- R12: The region word at offset 0x040 holds in bit 0 whether the last accepted in-range read targeted the data region, and in bits 2:1 how many words it committed (0, 1 or 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset for reads and writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| otpRdEn | output | 1 | Array read request |
| otpByteAddr | output | 14 | Array byte offset (word address × 4) |
| otpRdData | input | 32 | Array read data, valid the cycle after a request |
| otpRdErr | input | 1 | Array read failure, valid alongside otpRdData |

## Verification
The bench drives a colliding pair of events. A new command write lands in the same cycle that a two-word read commits its captures and raises done. The write is timed two cycles after the first command was taken, so it is sampled while the controller is still in its final fetch state. The bench counts it correct if the status shows done without the program flag, and if the captures hold the two fetched words. The array-access scoreboard must see no extra fetch.

// File: rtl/otpRdPkg.sv
package otpRdPkg;

  localparam logic [31:0] CMD_READ = 32'h23B1E361;
  localparam logic [31:0] CMD_PROG = 32'h23B1E364;

  localparam int OFF_CMD    = 'h000;
  localparam int OFF_ADDR   = 'h010;
  localparam int OFF_STATUS = 'h014;
  localparam int OFF_CAP0   = 'h020;
  localparam int OFF_CAP1   = 'h024;
  localparam int OFF_REGION = 'h040;

  typedef struct packed {
    logic latchBase;   // capture the address register as fetch base
    logic rdEn;        // issue an array read this cycle
    logic selNext;     // address base+1 instead of base
    logic stash0;      // hold first word of a pair
    logic commitOne;   // single-word commit
    logic commitTwo;   // two-word commit
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH0,
    ST_FETCH1,
    ST_FETCH2
  } ctrlState_t;

endpackage

// File: rtl/otpRdControl.sv
module otpRdControl
  import otpRdPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdWr,
  input  logic [31:0]  cmdVal,
  input  logic         addrInRange,
  input  logic         addrIsData,
  input  logic         otpRdErr,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic         progFlag
);

  ctrlState_t state;
  logic       twoWord;
  logic       isRead;
  logic       isProg;

  assign isRead = (cmdVal == CMD_READ);
  assign isProg = (cmdVal == CMD_PROG);
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      twoWord  <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      progFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdWr) begin
            if (isRead) begin
              done     <= 1'b0;
              progFlag <= 1'b0;
              if (addrInRange) begin
                err     <= 1'b0;
                twoWord <= addrIsData;
                state   <= ST_FETCH0;
              end else begin
                err <= 1'b1;
              end
            end else if (isProg) begin
              done     <= 1'b0;
              err      <= 1'b0;
              progFlag <= 1'b1;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_FETCH0: state <= ST_FETCH1;
        ST_FETCH1: begin
          if (otpRdErr) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else if (twoWord) begin
            state <= ST_FETCH2;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_FETCH2: begin
          if (otpRdErr) err <= 1'b1;
          else          done <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.latchBase = (state == ST_IDLE) && cmdWr && isRead && addrInRange;
    strobes.rdEn      = (state == ST_FETCH0) ||
                        ((state == ST_FETCH1) && twoWord && !otpRdErr);
    strobes.selNext   = (state == ST_FETCH1);
    strobes.stash0    = (state == ST_FETCH1) && twoWord && !otpRdErr;
    strobes.commitOne = (state == ST_FETCH1) && !twoWord && !otpRdErr;
    strobes.commitTwo = (state == ST_FETCH2) && !otpRdErr;
  end

endmodule

// File: rtl/otpRdDatapath.sv
module otpRdDatapath
  import otpRdPkg::*;
#(
  parameter int TOTAL_WORDS = 4096,
  parameter int DATA_WORDS  = 2048,
  localparam int WORD_AW    = $clog2(TOTAL_WORDS),
  localparam int BYTE_AW    = WORD_AW + 2
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               addrWr,
  input  logic [31:0]        wrData,
  input  ctrlStrobes_t       strobes,
  input  logic [31:0]        otpRdData,
  output logic [31:0]        addrReg,
  output logic               addrInRange,
  output logic               addrIsData,
  output logic [BYTE_AW-1:0] otpByteAddr,
  output logic [31:0]        cap0,
  output logic [31:0]        cap1,
  output logic [31:0]        regionWord
);

  logic [WORD_AW-1:0] baseAddr;
  logic [WORD_AW-1:0] wordSel;
  logic [31:0]        stashWord;
  logic               regionIsData;
  logic [1:0]         regionCount;

  assign addrInRange = (addrReg < 32'(TOTAL_WORDS));
  assign addrIsData  = (addrReg < 32'(DATA_WORDS));
  assign wordSel     = baseAddr + WORD_AW'(strobes.selNext);
  assign otpByteAddr = {wordSel, 2'b00};
  assign regionWord  = {29'd0, regionCount, regionIsData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrReg <= '0;
    else if (addrWr) addrReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr  <= '0;
      stashWord <= '0;
    end else begin
      if (strobes.latchBase) baseAddr  <= addrReg[WORD_AW-1:0];
      if (strobes.stash0)    stashWord <= otpRdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cap0 <= '0;
      cap1 <= '0;
    end else if (strobes.commitOne) begin
      cap0 <= otpRdData;
      cap1 <= '0;
    end else if (strobes.commitTwo) begin
      cap0 <= stashWord;
      cap1 <= otpRdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regionIsData <= 1'b0;
      regionCount  <= 2'd0;
    end else if (strobes.latchBase) begin
      regionIsData <= addrIsData;
      regionCount  <= 2'd0;
    end else if (strobes.commitOne) begin
      regionCount  <= 2'd1;
    end else if (strobes.commitTwo) begin
      regionCount  <= 2'd2;
    end
  end

endmodule

// File: rtl/otpReadCtrl.sv
module otpReadCtrl
  import otpRdPkg::*;
#(
  parameter int TOTAL_WORDS = 4096,
  parameter int DATA_WORDS  = 2048,
  parameter int REG_AW      = 8,
  localparam int WORD_AW    = $clog2(TOTAL_WORDS),
  localparam int BYTE_AW    = WORD_AW + 2
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               otpRdEn,
  output logic [BYTE_AW-1:0] otpByteAddr,
  input  logic [31:0]        otpRdData,
  input  logic               otpRdErr
);

  ctrlStrobes_t strobes;
  logic         cmdWr;
  logic         addrWr;
  logic         addrInRange;
  logic         addrIsData;
  logic         busy;
  logic         done;
  logic         err;
  logic         progFlag;
  logic [31:0]  addrReg;
  logic [31:0]  cap0;
  logic [31:0]  cap1;
  logic [31:0]  regionWord;
  logic [31:0]  statusWord;

  assign cmdWr      = regWrEn && (regAddr == REG_AW'(OFF_CMD));
  assign addrWr     = regWrEn && (regAddr == REG_AW'(OFF_ADDR));
  assign otpRdEn    = strobes.rdEn;
  assign statusWord = {28'd0, progFlag, err, done, busy};

  otpRdControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWr      (cmdWr),
    .cmdVal     (regWrData),
    .addrInRange(addrInRange),
    .addrIsData (addrIsData),
    .otpRdErr   (otpRdErr),
    .strobes    (strobes),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .progFlag   (progFlag)
  );

  otpRdDatapath #(
    .TOTAL_WORDS(TOTAL_WORDS),
    .DATA_WORDS (DATA_WORDS)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .addrWr     (addrWr),
    .wrData     (regWrData),
    .strobes    (strobes),
    .otpRdData  (otpRdData),
    .addrReg    (addrReg),
    .addrInRange(addrInRange),
    .addrIsData (addrIsData),
    .otpByteAddr(otpByteAddr),
    .cap0       (cap0),
    .cap1       (cap1),
    .regionWord (regionWord)
  );

  always_comb begin
    case (regAddr)
      REG_AW'(OFF_ADDR):   regRdData = addrReg;
      REG_AW'(OFF_STATUS): regRdData = statusWord;
      REG_AW'(OFF_CAP0):   regRdData = cap0;
      REG_AW'(OFF_CAP1):   regRdData = cap1;
      REG_AW'(OFF_REGION): regRdData = regionWord;
      default:             regRdData = '0;
    endcase
  end

endmodule

// File: rtl/otpReadCtrlChecker.sv
module otpReadCtrlChecker #(
  parameter int BYTE_AW = 14
)(
  input logic               clk,
  input logic               rstN,
  input logic               otpRdEn,
  input logic [BYTE_AW-1:0] otpByteAddr,
  input logic               busy,
  input logic               done,
  input logic [31:0]        cap0,
  input logic [31:0]        cap1,
  input logic [1:0]         regionCount
);

  AST_FETCH_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    otpRdEn |-> busy); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9

  AST_NEXT_WORD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (otpRdEn && $past(otpRdEn)) |-> (otpByteAddr == $past(otpByteAddr) + BYTE_AW'(4))); // R5

  AST_CAP0_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cap0) |-> ($past(busy) && !busy)); // R2

  AST_CAP1_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cap1) |-> ($past(busy) && !busy)); // R6

  AST_SINGLE_CLEARS_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (done && regionCount == 2'd1) |-> (cap1 == 32'd0)); // R3

endmodule

bind otpReadCtrl otpReadCtrlChecker #(.BYTE_AW(BYTE_AW)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .otpRdEn    (otpRdEn),
  .otpByteAddr(otpByteAddr),
  .busy       (busy),
  .done       (done),
  .cap0       (cap0),
  .cap1       (cap1),
  .regionCount(regionWord[2:1])
);

// File: tb/otpReadCtrl_test.sv
module otpReadCtrl_test;

  localparam logic [31:0] RD_CMD   = 32'h23B1E361;
  localparam logic [31:0] PRG_CMD  = 32'h23B1E364;
  localparam logic [7:0]  A_CMD    = 8'h00;
  localparam logic [7:0]  A_ADDR   = 8'h10;
  localparam logic [7:0]  A_STAT   = 8'h14;
  localparam logic [7:0]  A_CAP0   = 8'h20;
  localparam logic [7:0]  A_CAP1   = 8'h24;
  localparam logic [7:0]  A_REGION = 8'h40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        otpRdEn;
  logic [13:0] otpByteAddr;
  logic [31:0] otpRdData;
  logic        otpRdErr;
  logic [15:0] errWord = 16'hFFFF;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [13:0] fetchQ[$];

  always #10 clk = ~clk;

  otpReadCtrl uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .otpRdEn(otpRdEn),
    .otpByteAddr(otpByteAddr), .otpRdData(otpRdData), .otpRdErr(otpRdErr)
  );

  function automatic logic [31:0] wordAt(input logic [11:0] w);
    return {4'hA, w ^ 12'h5C3, 4'h6, w};
  endfunction

  // behavioural array: one-cycle read latency, error on a chosen word
  always_ff @(posedge clk) begin
    otpRdData <= otpRdEn ? wordAt(otpByteAddr[13:2]) : 32'hDEAD_BEEF;
    otpRdErr  <= otpRdEn && ({4'd0, otpByteAddr[13:2]} == errWord);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // monitor: pops expected array accesses in order
  always @(negedge clk) begin
    if (rstN && otpRdEn) begin
      checks++;
      if (fetchQ.size() == 0) begin
        fails++;
        $display("FAIL R5: actual fetch 0x%04h expected none", otpByteAddr);
      end else begin
        logic [13:0] e;
        e = fetchQ.pop_front();
        if (otpByteAddr !== e) begin
          fails++;
          $display("FAIL R5: actual fetch 0x%04h expected 0x%04h", otpByteAddr, e);
        end
      end
    end
  end

  task automatic busWrite(input logic [7:0] off, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = off; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] off, output logic [31:0] v);
    regAddr = off;
    #1;
    v = regRdData;
  endtask

  task automatic expectFetch(input logic [11:0] w);
    fetchQ.push_back({w, 2'b00});
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] cmd, input int waitCyc);
    busWrite(A_ADDR, a);
    busWrite(A_CMD, cmd);
    repeat (waitCyc) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(A_STAT, v);   check("R1 status", v, 0);
    readReg(A_CAP0, v);   check("R1 cap0", v, 0);
    readReg(A_CAP1, v);   check("R1 cap1", v, 0);
    readReg(A_REGION, v); check("R1 region", v, 0);
    readReg(A_ADDR, v);   check("R1 addr", v, 0);
    check("R1 rdEn", {31'd0, otpRdEn}, 0);

    // R2/R11 two-word data read with cycle timing
    expectFetch(12'h010); expectFetch(12'h011);
    issue(32'h10, RD_CMD, 0);
    readReg(A_ADDR, v); check("R2 addr readback", v, 32'h10);
    @(negedge clk);
    readReg(A_STAT, v); check("R11 busy after E0+1", v, 32'h1);
    @(negedge clk);
    readReg(A_STAT, v); check("R11 two-word busy after E0+2", v, 32'h1);
    @(negedge clk);
    readReg(A_STAT, v); check("R11 two-word done after E0+3", v, 32'h2);
    readReg(A_CAP0, v); check("R2 cap0", v, wordAt(12'h010));
    readReg(A_CAP1, v); check("R2 cap1", v, wordAt(12'h011));
    readReg(A_REGION, v); check("R12 data two words", v, 32'h5);

    // R2 last data entry crosses into next word
    expectFetch(12'h7FF); expectFetch(12'h800);
    issue(32'h7FF, RD_CMD, 3);
    readReg(A_CAP0, v); check("R2 edge cap0", v, wordAt(12'h7FF));
    readReg(A_CAP1, v); check("R2 edge cap1", v, wordAt(12'h800));

    // R3/R11 single-word config read
    expectFetch(12'h900);
    issue(32'h900, RD_CMD, 1);
    readReg(A_STAT, v); check("R11 single busy after E0+1", v, 32'h1);
    @(negedge clk);
    readReg(A_STAT, v); check("R11 single done after E0+2", v, 32'h2);
    readReg(A_CAP0, v); check("R3 cap0", v, wordAt(12'h900));
    readReg(A_CAP1, v); check("R3 cap1 zeroed", v, 0);
    readReg(A_REGION, v); check("R12 config one word", v, 32'h2);

    // R3 last in-range word
    expectFetch(12'hFFF);
    issue(32'hFFF, RD_CMD, 2);
    readReg(A_CAP0, v); check("R3 top cap0", v, wordAt(12'hFFF));
    readReg(A_CAP1, v); check("R3 top cap1", v, 0);

    // R8 unrecognised command: err set, done kept, no fetch
    busWrite(A_CMD, 32'h1234_5678);
    repeat (2) @(negedge clk);
    readReg(A_STAT, v); check("R8 status", v, 32'h6);
    readReg(A_CAP0, v); check("R8 cap0 kept", v, wordAt(12'hFFF));

    // R4 out of range
    issue(32'h1000, RD_CMD, 3);
    readReg(A_STAT, v); check("R4 status", v, 32'h4);
    readReg(A_CAP0, v); check("R4 cap0 kept", v, wordAt(12'hFFF));
    readReg(A_CAP1, v); check("R4 cap1 kept", v, 0);
    readReg(A_REGION, v); check("R4 region kept", v, 32'h2);

    // R7 program command
    busWrite(A_CMD, PRG_CMD);
    repeat (2) @(negedge clk);
    readReg(A_STAT, v); check("R7 status", v, 32'h8);
    readReg(A_CAP0, v); check("R7 cap0 kept", v, wordAt(12'hFFF));

    // R6 second-word failure; R9 program flag cleared on accept
    errWord = 16'h0021;
    expectFetch(12'h020); expectFetch(12'h021);
    issue(32'h20, RD_CMD, 3);
    readReg(A_STAT, v); check("R6/R9 status second fail", v, 32'h4);
    readReg(A_CAP0, v); check("R6 cap0 kept", v, wordAt(12'hFFF));
    readReg(A_CAP1, v); check("R6 cap1 kept", v, 0);
    readReg(A_REGION, v); check("R12 data none committed", v, 32'h1);

    // R6 first-word failure: no second fetch
    errWord = 16'h0030;
    expectFetch(12'h030);
    issue(32'h30, RD_CMD, 3);
    readReg(A_STAT, v); check("R6 status first fail", v, 32'h4);
    readReg(A_CAP0, v); check("R6 first-fail cap0 kept", v, wordAt(12'hFFF));
    errWord = 16'hFFFF;

    // R10 command landing in the commit cycle is dropped
    expectFetch(12'h050); expectFetch(12'h051);
    issue(32'h50, RD_CMD, 2);
    busWrite(A_CMD, PRG_CMD);
    @(negedge clk);
    readReg(A_STAT, v); check("R10 status no prog", v, 32'h2);
    readReg(A_CAP0, v); check("R10 cap0", v, wordAt(12'h050));
    readReg(A_CAP1, v); check("R10 cap1", v, wordAt(12'h051));

    repeat (2) @(negedge clk);
    check("R5 all fetches seen", fetchQ.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule